// File: doc/BRIEF.md
# Timed Interrupt Holdoff Counter

This block keeps the processor from taking interrupts for a programmed number of instruction cycles. An execute strobe, one clock wide and carrying a count operand, opens a holdoff window. That window covers the strobe cycle itself plus as many further instruction cycles as the operand gives.

While the window is open, every raw interrupt request line is forced low on the way to the interrupt controller, and a holdoff flag is raised. A down-counter measures the window. It advances only on cycles where the instruction-cycle enable is high, so pipeline stalls stretch the window in clock time without changing its length in instructions.

A second strobe always re-arms the counter with its own operand. This holds whether the counter is still running, is on its final counted cycle, or has just returned to zero. The window therefore never drops open between two back-to-back holdoff requests.

Top module: `irq_hold_timer`

## Requirements
- R1: While reset is asserted and no strobe is present, `hold_active` is 0 and `irq_masked` equals `irq_raw`; reset also abandons any window in progress.
- R2: In the clock cycle where `exec_stb` is 1, `hold_active` is 1 and `irq_masked` is all zeros, with no register delay.
- R3: With `cyc_en` held at 1, a strobe carrying operand N keeps `hold_active` at 1 for exactly N+1 consecutive cycles: the strobe cycle and N counted cycles after it.
- R4: A strobe with operand 0 holds interrupts off for exactly one cycle, the strobe cycle.
- R5: The counter decrements only on cycles where `cyc_en` is 1; cycles with `cyc_en` at 0 inside the window keep `hold_active` at 1 and add to its length.
- R6: A strobe that arrives while a window is running reloads the counter with its own operand, so the window ends N+1 enabled cycles after the new strobe, whether that is earlier or later than the old end.
- R7: A strobe arriving on the last counted cycle of a window, or on the first cycle after the count has reached zero, loads its operand and keeps `hold_active` at 1 with no cycle of release in between.
- R8: Whenever `hold_active` is 0, `irq_masked` equals `irq_raw` bit for bit; whenever it is 1, `irq_masked` is all zeros.
- R9: Once the count has expired and no strobe is present, `hold_active` returns to 0 and stays there until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_en | input | 1 | Instruction-cycle enable; the counter advances only when high |
| exec_stb | input | 1 | One-cycle strobe from the holdoff instruction |
| exec_cnt | input | CNT_W (14) | Count operand that comes with the strobe |
| irq_raw | input | NUM_IRQ (8) | Interrupt requests before gating |
| hold_active | output | 1 | High while interrupts are held off; also the status bit |
| irq_masked | output | NUM_IRQ (8) | Interrupt requests after gating |

## Verification
On every cycle, the assertions check the gating of the request lines against the holdoff flag, R2 (the flag goes high in the strobe cycle), and R5 (a stalled cycle cannot release a window). They also check R4 (a zero operand gives no carry-over) and the reload that follows a non-zero strobe. The exact window length of N+1 enabled cycles, the point at which a window ends after a reload, and the absence of a gap when a strobe lands on the zero-crossing cycle are counting properties. Only the bench scenarios show these: they measure whole windows and compare each against the operand.

// File: rtl/irq_hold_pkg.sv
package irq_hold_pkg;
   localparam int unsigned HOLD_CNT_W_DEF = 14;
   localparam int unsigned HOLD_IRQ_N_DEF = 8;

   // counter state as seen by the top level
   typedef enum logic [1:0] {
      HOLD_IDLE   = 2'b00,
      HOLD_LOAD   = 2'b01,
      HOLD_COUNT  = 2'b10
   } hold_phase_e;
endpackage

// File: rtl/irq_hold_count.sv
module irq_hold_count #(
   parameter int unsigned CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   output logic             busy
);
   localparam logic [CNT_W-1:0] ZERO = '0;
   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   // a load always wins, so a strobe on the zero-crossing cycle re-arms
   always_comb begin
      cnt_d = cnt_q;
      if (load)
         cnt_d = load_val;
      else if (step && (cnt_q != ZERO))
         cnt_d = cnt_q - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= ZERO;
      else
         cnt_q <= cnt_d;
   end

   assign busy = (cnt_q != ZERO);
endmodule

// File: rtl/irq_hold_gate.sv
module irq_hold_gate #(
   parameter int unsigned NUM_IRQ = 8
) (
   input  logic               block,
   input  logic [NUM_IRQ-1:0] req_in,
   output logic [NUM_IRQ-1:0] req_out
);
   for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      assign req_out[i] = req_in[i] & ~block;
   end
endmodule

// File: rtl/irq_hold_timer.sv
module irq_hold_timer
   import irq_hold_pkg::*;
#(
   parameter int unsigned CNT_W   = HOLD_CNT_W_DEF,
   parameter int unsigned NUM_IRQ = HOLD_IRQ_N_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cyc_en,
   input  logic               exec_stb,
   input  logic [CNT_W-1:0]   exec_cnt,
   input  logic [NUM_IRQ-1:0] irq_raw,
   output logic               hold_active,
   output logic [NUM_IRQ-1:0] irq_masked
);
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("irq_hold_timer: CNT_W must lie in 1..32");
   end
   if (NUM_IRQ < 1) begin : g_bad_num_irq
      $error("irq_hold_timer: NUM_IRQ must be at least 1");
   end

   logic        cnt_busy;
   hold_phase_e phase;

   irq_hold_count #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (exec_stb),
      .load_val (exec_cnt),
      .step     (cyc_en),
      .busy     (cnt_busy)
   );

   always_comb begin
      if (exec_stb)
         phase = HOLD_LOAD;
      else if (cnt_busy)
         phase = HOLD_COUNT;
      else
         phase = HOLD_IDLE;
   end

   assign hold_active = (phase != HOLD_IDLE);

   irq_hold_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
      .block   (hold_active),
      .req_in  (irq_raw),
      .req_out (irq_masked)
   );
endmodule

// File: rtl/irq_hold_timer_chk.sv
module irq_hold_timer_chk #(
   parameter int unsigned CNT_W   = 14,
   parameter int unsigned NUM_IRQ = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cyc_en,
   input logic               exec_stb,
   input logic [CNT_W-1:0]   exec_cnt,
   input logic [NUM_IRQ-1:0] irq_raw,
   input logic               hold_active,
   input logic [NUM_IRQ-1:0] irq_masked
);
   p_gate_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active |-> (irq_masked == '0));

   p_gate_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_active |-> (irq_masked == irq_raw));

   p_strobe_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stb |-> hold_active);

   p_reload_carries_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_stb && (exec_cnt != '0)) |=> hold_active);

   p_zero_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_stb && (exec_cnt == '0)) |=> (hold_active == exec_stb));

   p_stall_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_active && !exec_stb && !cyc_en) |=> hold_active);
endmodule

bind irq_hold_timer irq_hold_timer_chk #(.CNT_W(CNT_W), .NUM_IRQ(NUM_IRQ)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cyc_en      (cyc_en),
   .exec_stb    (exec_stb),
   .exec_cnt    (exec_cnt),
   .irq_raw     (irq_raw),
   .hold_active (hold_active),
   .irq_masked  (irq_masked)
);

// File: tb/tb_irq_hold_timer.sv
`timescale 1ns/1ps
module tb_irq_hold_timer;
   localparam int CW = 14;
   localparam int NI = 8;
   localparam int NVEC = 7;
   // each entry: operand in [31:16], expected held cycles in [15:0]
   localparam logic [31:0] VEC [NVEC] = '{
      {16'd0,   16'd1},
      {16'd1,   16'd2},
      {16'd2,   16'd3},
      {16'd5,   16'd6},
      {16'd13,  16'd14},
      {16'd300, 16'd301},
      {16'd16383, 16'd16384}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cyc_en = 1'b1;
   logic          exec_stb = 1'b0;
   logic [CW-1:0] exec_cnt = '0;
   logic [NI-1:0] irq_raw = 8'hA5;
   logic          hold_active;
   logic [NI-1:0] irq_masked;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   irq_hold_timer #(.CNT_W(CW), .NUM_IRQ(NI)) dut (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .exec_stb(exec_stb),
      .exec_cnt(exec_cnt), .irq_raw(irq_raw),
      .hold_active(hold_active), .irq_masked(irq_masked)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one instruction cycle: drive after the falling edge, settle, then sample
   task automatic tick(input logic s, input logic [CW-1:0] op, input logic e);
      @(negedge clk);
      exec_stb = s;
      exec_cnt = op;
      cyc_en   = e;
      #1;
   endtask

   task automatic drain(output int n);
      n = 0;
      while (hold_active && n < 20000) begin
         tick(1'b0, '0, 1'b1);
         if (hold_active) n++;
      end
   endtask

   initial begin
      int n;
      logic [CW-1:0] op;
      int exp;
      // R1: reset state
      #3;
      chk(hold_active == 1'b0, "R1", hold_active, 0);
      chk(irq_masked == irq_raw, "R1", irq_masked, irq_raw);
      @(negedge clk); rst_n = 1'b1;

      // R3 / R4 / R9: table of operands walked by one loop
      for (int i = 0; i < NVEC; i++) begin
         op  = CW'(VEC[i][31:16]);
         exp = int'(VEC[i][15:0]);
         tick(1'b1, op, 1'b1);
         chk(irq_masked == '0, "R2", irq_masked, 0);
         n = hold_active ? 1 : 0;
         drain(exp);
         n += exp;
         exp = int'(VEC[i][15:0]);
         chk(n == exp, (op == 0) ? "R4" : "R3", n, exp);
         tick(1'b0, '0, 1'b1);
         chk(hold_active == 1'b0, "R9", hold_active, 0);
      end

      // R8: open gate passes requests through
      irq_raw = 8'h3C;
      tick(1'b0, '0, 1'b1);
      chk(irq_masked == 8'h3C, "R8", irq_masked, 8'h3C);

      // R5: stalls stretch the window (operand 3, enables 0,0,1,1,0,1)
      tick(1'b1, CW'(3), 1'b1);
      n = 0;
      tick(1'b0, '0, 1'b0); n += hold_active;
      tick(1'b0, '0, 1'b0); n += hold_active;
      tick(1'b0, '0, 1'b1); n += hold_active;
      tick(1'b0, '0, 1'b1); n += hold_active;
      tick(1'b0, '0, 1'b0); n += hold_active;
      tick(1'b0, '0, 1'b1); n += hold_active;
      chk(n == 6, "R5", n, 6);
      tick(1'b0, '0, 1'b1);
      chk(hold_active == 1'b0, "R5", hold_active, 0);

      // R6: reload shortens a running window
      tick(1'b1, CW'(10), 1'b1);
      tick(1'b0, '0, 1'b1);
      tick(1'b0, '0, 1'b1);
      tick(1'b1, CW'(2), 1'b1);
      n = hold_active ? 1 : 0;
      drain(exp); n += exp;
      chk(n == 3, "R6", n, 3);

      // R6: reload lengthens a running window
      tick(1'b1, CW'(2), 1'b1);
      tick(1'b0, '0, 1'b1);
      tick(1'b1, CW'(5), 1'b1);
      n = hold_active ? 1 : 0;
      drain(exp); n += exp;
      chk(n == 6, "R6", n, 6);

      // R7: strobe on the last counted cycle (counter at one)
      tick(1'b1, CW'(4), 1'b1);
      tick(1'b0, '0, 1'b1);
      tick(1'b0, '0, 1'b1);
      tick(1'b0, '0, 1'b1);
      tick(1'b1, CW'(3), 1'b1);
      chk(hold_active == 1'b1, "R7", hold_active, 1);
      n = 1;
      drain(exp); n += exp;
      chk(n == 4, "R7", n, 4);

      // R7: strobe on the first cycle after the count reached zero
      tick(1'b1, CW'(1), 1'b1);
      tick(1'b0, '0, 1'b1);
      chk(hold_active == 1'b1, "R3", hold_active, 1);
      tick(1'b1, CW'(2), 1'b1);
      chk(hold_active == 1'b1, "R7", hold_active, 1);
      tick(1'b0, '0, 1'b1);
      chk(hold_active == 1'b1, "R7", hold_active, 1);
      tick(1'b0, '0, 1'b1);
      chk(hold_active == 1'b1, "R7", hold_active, 1);
      tick(1'b0, '0, 1'b1);
      chk(hold_active == 1'b0, "R9", hold_active, 0);

      // R1: reset abandons a running window
      tick(1'b1, CW'(50), 1'b1);
      tick(1'b0, '0, 1'b1);
      rst_n = 1'b0;
      #0.5;
      chk(hold_active == 1'b0, "R1", hold_active, 0);
      chk(irq_masked == irq_raw, "R1", irq_masked, irq_raw);
      @(negedge clk); rst_n = 1'b1;
      tick(1'b0, '0, 1'b1);
      chk(hold_active == 1'b0, "R1", hold_active, 0);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule